// File: doc/BRIEF.md
# BCD to Binary Adder-Tree Converter

This block turns a packed BCD word of up to four decimal digits into its unsigned binary value. Each BCD input bit carries a decimal weight: a digit bit times a power of ten. That weight is split into the powers of two it contains. The single-bit terms that result are gathered per binary column. Two terms in one column are merged with an OR gate when valid BCD makes them mutually exclusive, because a digit with its 8-bit set can have neither its 2-bit nor its 4-bit set. Each column's terms are counted with a balanced adder tree, and the weighted column counts are summed by a second balanced tree. No clock-by-clock iteration is needed.

The digit count is a parameter, so the default four-digit build and a two-digit, 7-bit build come from the same source. A per-digit check flags any nibble that holds a code above 9. An optional output register adds one cycle of latency and clears on an asynchronous active-low reset.

Top module: `bcd2bin_tree`

## Requirements
- R1: For every valid input, `bin_o` equals 1000*thousands + 100*hundreds + 10*tens + units. Units sit in `bcd_i[3:0]`, tens in `[7:4]`, hundreds in `[11:8]` and thousands in `[15:12]`.
- R2: The output is `clog2(10**NUM_DEC)` bits wide, which is 14 bits by default. The largest input, 9999, gives 9999 (0x270F). No carry beyond the top output bit is produced.
- R3: `digits_ok_o` is 1 when every nibble holds 0 to 9. It is 0 when any nibble holds a code from 10 to 15. While it is 0, `bin_o` is a don't-care.
- R4: With `REG_OUT=0`, the outputs follow `bcd_i` in the same cycle. With `REG_OUT=1`, they update on the first rising edge of `clk_i` after the input is applied, and they hold their previous value until that edge.
- R5: With `REG_OUT=1`, a low `rst_ni` forces `bin_o` to 0 and `digits_ok_o` to 0 at once, without waiting for a clock edge.
- R6: With `NUM_DEC=2`, the block takes 8 input bits and gives a 7-bit result. All 100 values from 00 to 99 convert exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| bcd_i | input | 4*NUM_DEC | Packed BCD digits, least significant digit in the low nibble |
| bin_o | output | clog2(10**NUM_DEC) | Binary equivalent |
| digits_ok_o | output | 1 | All nibbles are valid decimal digits |

## Verification
In the combinational build, `bin_o` and `digits_ok_o` are due one time step after `bcd_i` changes. The bench drives each input on the falling clock edge and samples 1 ns later. In the registered build, the result is due just after the next rising edge. The bench samples the registered instance both before that edge, where it expects the previous value, and 1 ns after it, where it expects the new value. For the reset check, the bench samples between clock edges to show that reset clears the register without a clock.

// File: rtl/bcd2bin_pkg.sv
`timescale 1ns/1ps
package bcd2bin_pkg;

  function automatic int pow10(input int d);
    int r = 1;
    for (int i = 0; i < d; i++) r = r * 10;
    return r;
  endfunction

  function automatic int bin_width(input int nd);
    return $clog2(pow10(nd));
  endfunction

  // digit d, bit b contributes a term to column c
  function automatic bit raw_has(input int c, input int d, input int b);
    if (c < b) return 1'b0;
    return ((pow10(d) >> (c - b)) & 1) == 1;
  endfunction

  // bit 3 of a digit excludes bits 1 and 2: choose one OR partner per column
  function automatic int partner(input int c, input int d);
    if (!raw_has(c, d, 3)) return -1;
    if (raw_has(c, d, 1)) return d * 4 + 1;
    if (raw_has(c, d, 2)) return d * 4 + 2;
    return -1;
  endfunction

  function automatic int n_slots(input int nd, input int c);
    int n = 0;
    for (int d = 0; d < nd; d++)
      for (int b = 0; b < 4; b++) begin
        if (!raw_has(c, d, b)) continue;
        if (b != 3 && partner(c, d) == d * 4 + b) continue;
        n++;
      end
    return n;
  endfunction

  // slot k of column c: (src_a+1)*64 + (src_b+1), src_b = -1 when unmerged
  function automatic int slot_code(input int nd, input int c, input int k);
    int n = 0;
    for (int d = 0; d < nd; d++)
      for (int b = 0; b < 4; b++) begin
        if (!raw_has(c, d, b)) continue;
        if (b != 3 && partner(c, d) == d * 4 + b) continue;
        if (n == k) return (d * 4 + b + 1) * 64 + ((b == 3) ? partner(c, d) + 1 : 0);
        n++;
      end
    return 0;
  endfunction

endpackage

// File: rtl/bcd_digit_check.sv
`timescale 1ns/1ps
module bcd_digit_check (
  input  logic [3:0] digit_i,
  output logic       ok_o
);
  // codes 10..15 all have bit 3 set together with bit 2 or bit 1
  assign ok_o = ~(digit_i[3] & (digit_i[2] | digit_i[1]));
endmodule

// File: rtl/wtree_add.sv
`timescale 1ns/1ps
module wtree_add #(
  parameter  int N  = 2,
  parameter  int W  = 4,
  localparam int LV = (N > 1) ? $clog2(N) : 0,
  localparam int SZ = 1 << LV
) (
  input  logic [N*W-1:0] ops_i,
  output logic [W-1:0]   sum_o
);
  for (genvar l = 0; l <= LV; l++) begin : g_lv
    logic [W-1:0] v [SZ >> l];
    for (genvar i = 0; i < (SZ >> l); i++) begin : g_node
      if (l == 0) begin : g_leaf
        if (i < N) begin : g_op
          assign v[i] = ops_i[i*W +: W];
        end else begin : g_pad
          assign v[i] = '0;
        end
      end else begin : g_add
        assign v[i] = g_lv[l-1].v[2*i] + g_lv[l-1].v[2*i+1];
      end
    end
  end
  assign sum_o = g_lv[LV].v[0];
endmodule

// File: rtl/bcd2bin_tree.sv
`timescale 1ns/1ps
module bcd2bin_tree
  import bcd2bin_pkg::*;
#(
  parameter  int NUM_DEC = 4,
  parameter  bit REG_OUT = 1'b0,
  localparam int IN_W    = 4 * NUM_DEC,
  localparam int BIN_W   = bin_width(NUM_DEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  bcd_i,
  output logic [BIN_W-1:0] bin_o,
  output logic             digits_ok_o
);
  localparam int CNT_W = $clog2(IN_W + 1);

  logic [CNT_W-1:0]       col_cnt [BIN_W];
  logic [BIN_W*BIN_W-1:0] rows;
  logic [BIN_W-1:0]       bin_sum;
  logic [NUM_DEC-1:0]     dec_ok;
  logic                   ok_all;

  // per-column term count, OR-merged where terms are exclusive
  for (genvar c = 0; c < BIN_W; c++) begin : g_col
    localparam int NS = n_slots(NUM_DEC, c);
    if (NS == 0) begin : g_empty
      assign col_cnt[c] = '0;
    end else begin : g_terms
      logic [NS*CNT_W-1:0] ops;
      for (genvar k = 0; k < NS; k++) begin : g_slot
        localparam int CODE = slot_code(NUM_DEC, c, k);
        localparam int SA   = CODE / 64 - 1;
        localparam int SB   = CODE % 64 - 1;
        if (SB < 0) begin : g_single
          assign ops[k*CNT_W +: CNT_W] = CNT_W'(bcd_i[SA]);
        end else begin : g_or
          assign ops[k*CNT_W +: CNT_W] = CNT_W'(bcd_i[SA] | bcd_i[SB]);
        end
      end
      wtree_add #(.N(NS), .W(CNT_W)) u_pop (
        .ops_i (ops),
        .sum_o (col_cnt[c])
      );
    end
    // truncation to BIN_W drops the impossible top carry
    assign rows[c*BIN_W +: BIN_W] = BIN_W'(col_cnt[c]) << c;
  end

  wtree_add #(.N(BIN_W), .W(BIN_W)) u_sum (
    .ops_i (rows),
    .sum_o (bin_sum)
  );

  for (genvar d = 0; d < NUM_DEC; d++) begin : g_dig
    bcd_digit_check u_dchk (
      .digit_i (bcd_i[4*d +: 4]),
      .ok_o    (dec_ok[d])
    );
  end
  assign ok_all = &dec_ok;

  if (REG_OUT) begin : g_reg
    logic [BIN_W-1:0] bin_q;
    logic             ok_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bin_q <= '0;
        ok_q  <= 1'b0;
      end else begin
        bin_q <= bin_sum;
        ok_q  <= ok_all;
      end
    end
    assign bin_o       = bin_q;
    assign digits_ok_o = ok_q;
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = clk_i ^ rst_ni;
    assign bin_o       = bin_sum;
    assign digits_ok_o = ok_all;
  end
endmodule

// File: rtl/bcd2bin_tree_chk.sv
`timescale 1ns/1ps
module bcd2bin_tree_chk
  import bcd2bin_pkg::*;
#(
  parameter  int NUM_DEC = 4,
  parameter  bit REG_OUT = 1'b0,
  localparam int IN_W    = 4 * NUM_DEC,
  localparam int BIN_W   = bin_width(NUM_DEC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IN_W-1:0]  bcd_i,
  input logic [BIN_W-1:0] bin_o,
  input logic             digits_ok_o
);
  function automatic int ref_val(input logic [IN_W-1:0] v);
    int s = 0;
    for (int d = 0; d < NUM_DEC; d++) s = s + int'(v[4*d +: 4]) * pow10(d);
    return s;
  endfunction

  function automatic bit nib_ok(input logic [IN_W-1:0] v);
    for (int d = 0; d < NUM_DEC; d++)
      if (v[4*d +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && digits_ok_o |-> int'(bin_o) < pow10(NUM_DEC));

  if (!REG_OUT) begin : g_comb
    p_value_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && digits_ok_o |-> int'(bin_o) == ref_val(bcd_i));
    p_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed |-> digits_ok_o == nib_ok(bcd_i));
    p_invalid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && !nib_ok(bcd_i) |-> !digits_ok_o);
  end else begin : g_reg
    p_latency_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed |-> digits_ok_o == nib_ok($past(bcd_i)));
    p_latency_value_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && digits_ok_o |-> int'(bin_o) == ref_val($past(bcd_i)));
    p_invalid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && !nib_ok($past(bcd_i)) |-> !digits_ok_o);
  end
endmodule

bind bcd2bin_tree bcd2bin_tree_chk #(.NUM_DEC(NUM_DEC), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_bcd2bin_tree.sv
`timescale 1ns/1ps
module sim_bcd2bin_tree;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] bcd4 = 16'h0000;
  logic [7:0]  bcd2 = 8'h00;
  logic [13:0] bin_u0, bin_u1;
  logic [6:0]  bin_u2;
  logic        ok_u0, ok_u1, ok_u2;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  bcd2bin_tree u0 (.clk_i(clk_i), .rst_ni(rst_ni), .bcd_i(bcd4), .bin_o(bin_u0), .digits_ok_o(ok_u0));
  bcd2bin_tree #(.NUM_DEC(4), .REG_OUT(1'b1)) u1 (.clk_i(clk_i), .rst_ni(rst_ni), .bcd_i(bcd4), .bin_o(bin_u1), .digits_ok_o(ok_u1));
  bcd2bin_tree #(.NUM_DEC(2), .REG_OUT(1'b0)) u2 (.clk_i(clk_i), .rst_ni(rst_ni), .bcd_i(bcd2), .bin_o(bin_u2), .digits_ok_o(ok_u2));

  localparam int NV = 14;
  localparam logic [15:0] TV_IN [NV] = '{16'h0000, 16'h0001, 16'h0009, 16'h0010, 16'h0080, 16'h0099, 16'h0800,
                                         16'h0999, 16'h8000, 16'h8888, 16'h9999, 16'h2480, 16'h4096, 16'h1234};
  localparam int TV_EXP [NV] = '{0, 1, 9, 10, 80, 99, 800, 999, 8000, 8888, 9999, 2480, 4096, 1234};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    int prev;
    // R5: reset holds the registered outputs at zero
    bcd4 = 16'h9999;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R5 reset bin", int'(bin_u1), 0);
    chk("R5 reset ok", int'(ok_u1), 0);
    rst_ni = 1'b1;

    // R1 R2 table of corner vectors
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      bcd4 = TV_IN[i];
      #1;
      chk("R1 table bin", int'(bin_u0), TV_EXP[i]);
      chk("R1 table ok", int'(ok_u0), 1);
      if (TV_EXP[i] == 9999) chk("R2 max value", int'(bin_u0), 9999);
    end

    @(negedge clk_i);
    bcd4 = 16'h0000;
    @(posedge clk_i);
    prev = 0;
    // R1 exhaustive, R4 latency of the registered build
    for (int th = 0; th < 10; th++)
      for (int h = 0; h < 10; h++)
        for (int t = 0; t < 10; t++)
          for (int u = 0; u < 10; u++) begin
            int exp;
            exp = th * 1000 + h * 100 + t * 10 + u;
            @(negedge clk_i);
            bcd4 = {4'(th), 4'(h), 4'(t), 4'(u)};
            #1;
            chk("R1 sweep", int'(bin_u0), exp);
            chk("R1 sweep ok", int'(ok_u0), 1);
            chk("R4 before edge", int'(bin_u1), prev);
            @(posedge clk_i);
            #1;
            chk("R4 after edge", int'(bin_u1), exp);
            chk("R4 ok after edge", int'(ok_u1), 1);
            prev = exp;
          end

    // R6 two-digit variant
    for (int t = 0; t < 10; t++)
      for (int u = 0; u < 10; u++) begin
        bcd2 = {4'(t), 4'(u)};
        #1;
        chk("R6 two-digit", int'(bin_u2), t * 10 + u);
        chk("R6 two-digit ok", int'(ok_u2), 1);
      end

    // R3 invalid digit codes in every position
    for (int pos = 0; pos < 4; pos++)
      for (int code = 10; code < 16; code++) begin
        logic [15:0] v;
        v = 16'h5555;
        v[4*pos +: 4] = 4'(code);
        @(negedge clk_i);
        bcd4 = v;
        #1;
        chk("R3 flag comb", int'(ok_u0), 0);
        @(posedge clk_i);
        #1;
        chk("R3 flag reg", int'(ok_u1), 0);
        if (pos < 2) begin
          logic [7:0] w;
          w = 8'h55;
          w[4*pos +: 4] = 4'(code);
          bcd2 = w;
          #1;
          chk("R3 flag two-digit", int'(ok_u2), 0);
        end
      end

    // R5 asynchronous clear between edges
    @(negedge clk_i);
    bcd4 = 16'h9999;
    @(posedge clk_i);
    #1;
    chk("R4 captured", int'(bin_u1), 9999);
    #3 rst_ni = 1'b0;
    #1;
    chk("R5 async bin", int'(bin_u1), 0);
    chk("R5 async ok", int'(ok_u1), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule